// File: doc/BRIEF.md
# Fine-Grained Multithreading Thread Selector

This block decides, every clock cycle, which of several hardware thread contexts may issue one instruction into a single-issue pipeline that interleaves threads. It rotates through the contexts in round-robin order and changes thread on every cycle. It passes over any context that outside logic has marked as suspended. It also passes over any context that is still waiting out a pipeline penalty.

Each context has its own stall countdown. The pipeline reports a penalty event for a context together with its kind. A short event covers a load-use hazard or a taken branch. A long event covers a first-level cache miss. The countdown makes the context ineligible for a fixed number of cycles. Because the other contexts take their turns while it counts down, short penalties are normally hidden completely. The selector reports the chosen context, a valid flag, and an idle flag that rises only when no context can issue.

Top module: `fgmt_thread_sel`

## Requirements
- R1: After reset all stall countdowns are zero and the rotation starts at context 0, so with every context active the first grant is context 0.
- R2: With every context active and no events, grants follow the order 0, 1, 2, 3, 0, ... and change on every cycle.
- R3: A context whose `thr_active` bit is 0 is never granted. The rotation moves on to the next eligible context in circular order.
- R4: A context whose countdown is non-zero is never granted.
- R5: A short event (`stall_ev[i]`=1, `stall_long[i]`=0) makes context i ineligible for the next 3 cycles. It is eligible again in the 4th cycle after the event cycle.
- R6: A long event (`stall_ev[i]`=1, `stall_long[i]`=1) makes context i ineligible for the next 23 cycles.
- R7: `issue_vld` is low and `pipe_idle` is high exactly when no context is both active and free of stall. The rotation position holds during such cycles.
- R8: After a grant to context g, the search in the next cycle starts at context (g+1) mod 4.
- R9: An event on a context that is already counting down sets the remaining count to the larger of the old count minus one and the new penalty.
- R10: With all four contexts active, a short event on the context granted in cycle c costs no issue slot: that context is granted again in cycle c+4 and every cycle in between has a grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| thr_active | input | NT | Per-context active flag (0 = suspended) |
| stall_ev | input | NT | Per-context penalty event strobe |
| stall_long | input | NT | Penalty kind for the event: 1 = cache miss (long), 0 = load-use or branch (short) |
| issue_tid | output | TW | Granted context number, meaningful when `issue_vld` is high |
| issue_vld | output | 1 | A context is granted this cycle |
| pipe_idle | output | 1 | No context can issue this cycle |

## Verification
The assertions check on every cycle four properties. A grant goes only to a context that is active and has a zero countdown. The idle flag agrees with eligibility. The rotation position advances past the granted context or holds when nothing is granted. Each countdown either loads its penalty or falls by exactly one. Whole-sequence effects can only be shown by the bench scenarios, which compare against a behavioural model on every cycle. These are that a short penalty disappears behind the other three contexts, that a long penalty on a lone active context leaves exactly 23 idle cycles, and that a short event arriving during a long countdown does not shorten it.

// File: rtl/fgmt_thread_sel.sv
module fgmt_thread_sel #(
  parameter int NT        = 4,
  parameter int SHORT_PEN = 3,
  parameter int LONG_PEN  = 23,
  localparam int TW = (NT > 1) ? $clog2(NT) : 1,
  localparam int CW = $clog2(LONG_PEN + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NT-1:0] thr_active,
  input  logic [NT-1:0] stall_ev,
  input  logic [NT-1:0] stall_long,
  output logic [TW-1:0] issue_tid,
  output logic          issue_vld,
  output logic          pipe_idle
);

  logic [TW-1:0]         ptr_q;
  logic [NT-1:0][CW-1:0] cnt_q;
  logic [NT-1:0][CW-1:0] cnt_d;
  logic [NT-1:0]         elig;

  for (genvar i = 0; i < NT; i++) begin : g_ctx
    logic [CW-1:0] dec, pen;
    assign dec      = (cnt_q[i] == '0) ? '0 : cnt_q[i] - 1'b1;
    assign pen      = stall_long[i] ? CW'(LONG_PEN) : CW'(SHORT_PEN);
    assign cnt_d[i] = !stall_ev[i] ? dec : ((dec > pen) ? dec : pen);
    assign elig[i]  = thr_active[i] && (cnt_q[i] == '0);
  end

  always_comb begin
    issue_vld = 1'b0;
    issue_tid = '0;
    for (int k = NT - 1; k >= 0; k--) begin
      int idx;
      idx = (int'(ptr_q) + k) % NT;
      if (elig[idx]) begin
        issue_vld = 1'b1;
        issue_tid = TW'(idx);
      end
    end
  end

  assign pipe_idle = ~issue_vld;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      if (issue_vld)
        ptr_q <= (int'(issue_tid) == NT - 1) ? '0 : issue_tid + 1'b1;
    end
  end

endmodule

module fgmt_thread_sel_chk #(
  parameter int NT        = 4,
  parameter int SHORT_PEN = 3,
  parameter int LONG_PEN  = 23,
  localparam int TW = (NT > 1) ? $clog2(NT) : 1,
  localparam int CW = $clog2(LONG_PEN + 1)
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [NT-1:0]         thr_active,
  input logic [NT-1:0]         stall_ev,
  input logic [NT-1:0]         stall_long,
  input logic [TW-1:0]         issue_tid,
  input logic                  issue_vld,
  input logic                  pipe_idle,
  input logic [TW-1:0]         ptr_q,
  input logic [NT-1:0][CW-1:0] cnt_q
);

  a_r3_grant_active: assert property (@(posedge clk) disable iff (!rst_n)
    issue_vld |-> thr_active[issue_tid]);

  a_r4_grant_unstalled: assert property (@(posedge clk) disable iff (!rst_n)
    issue_vld |-> cnt_q[issue_tid] == '0);

  a_r7_idle_flag: assert property (@(posedge clk) disable iff (!rst_n)
    pipe_idle != issue_vld);

  a_r7_ptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !issue_vld |=> $stable(ptr_q));

  a_r8_ptr_advance: assert property (@(posedge clk) disable iff (!rst_n)
    issue_vld |=> int'(ptr_q) == (int'($past(issue_tid)) + 1) % NT);

  for (genvar i = 0; i < NT; i++) begin : g_chk
    a_r7_idle_none_eligible: assert property (@(posedge clk) disable iff (!rst_n)
      pipe_idle |-> !(thr_active[i] && cnt_q[i] == '0));

    a_r5_short_load: assert property (@(posedge clk) disable iff (!rst_n)
      stall_ev[i] && !stall_long[i] |=> int'(cnt_q[i]) >= SHORT_PEN);

    a_r6_long_load: assert property (@(posedge clk) disable iff (!rst_n)
      stall_ev[i] && stall_long[i] |=> int'(cnt_q[i]) == LONG_PEN);

    a_r9_countdown: assert property (@(posedge clk) disable iff (!rst_n)
      !stall_ev[i] && cnt_q[i] != '0 |=> cnt_q[i] == $past(cnt_q[i]) - 1'b1);
  end

endmodule

bind fgmt_thread_sel fgmt_thread_sel_chk #(
  .NT(NT), .SHORT_PEN(SHORT_PEN), .LONG_PEN(LONG_PEN)
) u_chk (
  .clk(clk), .rst_n(rst_n), .thr_active(thr_active), .stall_ev(stall_ev),
  .stall_long(stall_long), .issue_tid(issue_tid), .issue_vld(issue_vld),
  .pipe_idle(pipe_idle), .ptr_q(ptr_q), .cnt_q(cnt_q)
);

// File: tb/tb_fgmt_thread_sel.sv
module tb_fgmt_thread_sel;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] thr_active = '0;
  logic [3:0] stall_ev = '0;
  logic [3:0] stall_long = '0;
  logic [1:0] issue_tid;
  logic       issue_vld;
  logic       pipe_idle;

  int errors = 0;
  int checks = 0;
  int m_cnt[4];
  int m_ptr = 0;
  bit done = 0;

  always #2 clk = ~clk;

  fgmt_thread_sel dut (
    .clk(clk), .rst_n(rst_n), .thr_active(thr_active), .stall_ev(stall_ev),
    .stall_long(stall_long), .issue_tid(issue_tid), .issue_vld(issue_vld),
    .pipe_idle(pipe_idle)
  );

  function automatic int pick(logic [3:0] act);
    for (int k = 0; k < 4; k++) begin
      int idx;
      idx = (m_ptr + k) % 4;
      if (act[idx] && m_cnt[idx] == 0) return idx;
    end
    return -1;
  endfunction

  function automatic void chk(string tag, int act_v, int exp_v, string what);
    checks++;
    if (act_v != exp_v) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act_v, exp_v);
    end
  endfunction

  task automatic step(logic [3:0] act, logic [3:0] ev, logic [3:0] lng, string tag);
    int g;
    thr_active = act; stall_ev = ev; stall_long = lng;
    #1;
    g = pick(act);
    chk(tag, int'(issue_vld), (g >= 0) ? 1 : 0, "valid");
    chk(tag, int'(pipe_idle), (g < 0) ? 1 : 0, "idle");
    if (g >= 0) chk(tag, int'(issue_tid), g, "thread");
    for (int i = 0; i < 4; i++) begin
      int d;
      d = (m_cnt[i] > 0) ? m_cnt[i] - 1 : 0;
      if (ev[i]) begin
        int p;
        p = lng[i] ? 23 : 3;
        d = (d > p) ? d : p;
      end
      m_cnt[i] = d;
    end
    if (g >= 0) m_ptr = (g + 1) % 4;
    @(negedge clk);
  endtask

  task automatic ev_on_grant(logic [3:0] act, bit lng, string tag);
    int g;
    logic [3:0] e;
    g = pick(act);
    e = (g >= 0) ? (4'b0001 << g) : 4'b0000;
    step(act, e, lng ? e : 4'b0000, tag);
  endtask

  initial begin
    int gaps;
    for (int i = 0; i < 4; i++) m_cnt[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: first grant after reset
    step(4'b1111, 4'b0, 4'b0, "R1");
    // R2: plain rotation
    for (int n = 0; n < 8; n++) step(4'b1111, 4'b0, 4'b0, "R2");
    // R3: suspended contexts skipped
    for (int n = 0; n < 6; n++) step(4'b1010, 4'b0, 4'b0, "R3");
    for (int n = 0; n < 6; n++) step(4'b0111, 4'b0, 4'b0, "R3");
    // R8: wrap with a sparse set
    for (int n = 0; n < 6; n++) step(4'b1001, 4'b0, 4'b0, "R8");
    // R10 and R5: short stall hidden behind three other contexts
    gaps = 0;
    ev_on_grant(4'b1111, 1'b0, "R10");
    for (int n = 0; n < 8; n++) begin
      if (pick(4'b1111) < 0) gaps++;
      step(4'b1111, 4'b0, 4'b0, "R10");
    end
    chk("R10", gaps, 0, "lost slots");
    // R5: short stall visible with two contexts
    ev_on_grant(4'b0011, 1'b0, "R5");
    for (int n = 0; n < 6; n++) step(4'b0011, 4'b0, 4'b0, "R5");
    // R4 and R6: long stall on one of two contexts
    ev_on_grant(4'b0110, 1'b1, "R6");
    for (int n = 0; n < 26; n++) step(4'b0110, 4'b0, 4'b0, "R4");
    // R7: lone context with long miss gives 23 idle cycles
    gaps = 0;
    ev_on_grant(4'b0001, 1'b1, "R7");
    for (int n = 0; n < 26; n++) begin
      if (pick(4'b0001) < 0) gaps++;
      step(4'b0001, 4'b0, 4'b0, "R7");
    end
    chk("R7", gaps, 23, "idle cycles");
    // R7: everyone stalled, then suspended
    step(4'b1111, 4'b1111, 4'b0000, "R7");
    for (int n = 0; n < 5; n++) step(4'b1111, 4'b0, 4'b0, "R7");
    for (int n = 0; n < 3; n++) step(4'b0000, 4'b0, 4'b0, "R7");
    // R9: short event during long countdown keeps the longer one
    step(4'b0100, 4'b0100, 4'b0100, "R9");
    for (int n = 0; n < 5; n++) step(4'b0100, 4'b0, 4'b0, "R9");
    step(4'b0100, 4'b0100, 4'b0000, "R9");
    for (int n = 0; n < 20; n++) step(4'b0100, 4'b0, 4'b0, "R9");
    // R9: long event during short countdown extends it
    step(4'b1000, 4'b1000, 4'b0000, "R9");
    step(4'b1000, 4'b1000, 4'b1000, "R9");
    for (int n = 0; n < 26; n++) step(4'b1000, 4'b0, 4'b0, "R9");
    // mixed traffic
    for (int n = 0; n < 40; n++)
      step(4'b1111, 4'(n * 5 % 16) & 4'(n % 3 == 0 ? 15 : 0), 4'(n % 7 == 0 ? 15 : 0), "R4");
    done = 1;
  end

  initial begin
    int cyc;
    cyc = 0;
    while (!done && cyc < 20000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog all: actual=hung expected=finished");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule